// File: doc/BRIEF.md
# LCD Frame Clock Divider

This block turns a fast input clock into the two timing strobes an LCD controller needs. The first is a one-cycle LCD clock tick that marks each drive slot. The second is a one-cycle start-of-frame pulse. The tick period is the product of a two-way prescaler ratio N and a programmable divider D. The frame spans K ticks, and K depends on the multiplexing duty. The block also returns the full frame divisor K×N×D, so that the frame rate can be read as the input clock divided by that number.

The three configuration inputs can change at any moment: the prescaler select, the divide code and the duty select. The block takes all three into a held copy only at a start-of-frame. A frame that is in progress therefore always completes at the length it began with. While reset is asserted, the held copy follows the inputs directly.

Top module: `lcdfd_frame_div`

## Requirements
- R1: `frame_div` equals K×N×D of the held configuration.
- R2: `lcd_tick` is high for one cycle every N×D cycles. N is 2^PRE_LO_LOG2 when `pre_sel` is 0 and 2^PRE_HI_LOG2 when it is 1. D is `div_code` + 1, so code 0 gives 1 and code 7 gives 8.
- R3: Consecutive `frame_sof` pulses are exactly K×N×D cycles apart.
- R4: `duty` codes are 2'b00 static, 2'b01 one half, 2'b10 one third and 2'b11 one quarter. K is 6 for one third and 8 for the other three codes. `frame_sof` only ever rises together with `lcd_tick`, once every K ticks.
- R5: Reset is synchronous and active high, and both strobes stay low while it is asserted. Counting the first cycle after release as cycle 0, the first tick carries the first `frame_sof`, in cycle N×D−1.
- R6: A change to `pre_sel`, `div_code` or `duty` takes effect only after the next `frame_sof`. The frame in progress keeps its length, and `frame_div` holds its value until then.
- R7: With the default parameters (N of 16 or 2048), `pre_sel`=1, code 3 and quarter duty give a divisor of 65536. `pre_sel`=0, code 4 and static duty give 640.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_sel | input | 1 | Prescaler ratio select: 0 low ratio, 1 high ratio |
| div_code | input | 3 | Divider code, D = code + 1 |
| duty | input | 2 | Duty select |
| lcd_tick | output | 1 | One-cycle prescaled LCD clock strobe |
| frame_sof | output | 1 | One-cycle start-of-frame strobe |
| frame_div | output | PRE_HI_LOG2+7 | Effective frame divisor K×N×D |

## Verification
The main instance is built with PRE_LO_LOG2=1 and PRE_HI_LOG2=3, so N is 2 or 8 and the longest frame is 512 cycles. At that size the bench can time several full frames for every duty code and for both ends of the divide code. It can also observe a configuration change made in the middle of a frame. A second instance keeps the default ratios of 16 and 2048 and is used only for the divisor read-back, where it reaches the 65536 and 640 cases.

// File: rtl/lcdfd_pkg.sv
package lcdfd_pkg;

    parameter int unsigned CODE_W = 3;
    parameter int unsigned FC_W   = 3;

    typedef enum logic [1:0] {
        DUTY_STATIC  = 2'b00,
        DUTY_HALF    = 2'b01,
        DUTY_THIRD   = 2'b10,
        DUTY_QUARTER = 2'b11
    } duty_e;

    typedef struct packed {
        logic              psel;
        logic [CODE_W-1:0] code;
        duty_e             duty;
    } lcd_cfg_t;

    function automatic logic [3:0] k_of(input duty_e d);
        return (d == DUTY_THIRD) ? 4'd6 : 4'd8;
    endfunction

endpackage

// File: rtl/lcdfd_cfg_hold.sv
module lcdfd_cfg_hold
    import lcdfd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     load,
    input  lcd_cfg_t cfg_in,
    output lcd_cfg_t cfg_q
);
    always_ff @(posedge clk) begin
        if (rst || load) begin
            cfg_q <= cfg_in;
        end
    end
endmodule

// File: rtl/lcdfd_prescaler.sv
module lcdfd_prescaler
    import lcdfd_pkg::*;
#(
    parameter int unsigned PRE_LO_LOG2 = 4,
    parameter int unsigned PRE_HI_LOG2 = 11
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              psel,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int unsigned PW = PRE_HI_LOG2;
    localparam logic [PW-1:0] HI_TERM = {PW{1'b1}};
    localparam logic [PW-1:0] LO_TERM = PW'((1 << PRE_LO_LOG2) - 1);

    logic [PW-1:0]     pc;
    logic [CODE_W-1:0] dc;
    logic [PW-1:0]     pterm;
    logic              p_wrap;

    generate
        if (PRE_LO_LOG2 == PRE_HI_LOG2) begin : g_single
            assign pterm = HI_TERM;
        end else begin : g_dual
            assign pterm = psel ? HI_TERM : LO_TERM;
        end
    endgenerate

    assign p_wrap = (pc == pterm);
    assign tick   = !rst && p_wrap && (dc == code);

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
            dc <= '0;
        end else if (p_wrap) begin
            pc <= '0;
            dc <= (dc == code) ? '0 : dc + 1'b1;
        end else begin
            pc <= pc + 1'b1;
        end
    end
endmodule

// File: rtl/lcdfd_frame_seq.sv
module lcdfd_frame_seq
    import lcdfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic [3:0] k_act,
    input  logic [3:0] k_init,
    output logic       sof
);
    logic [FC_W-1:0] fc;
    logic [FC_W-1:0] k_last;

    assign k_last = FC_W'(k_act - 4'd1);
    assign sof    = tick && (fc == k_last);

    always_ff @(posedge clk) begin
        if (rst) begin
            fc <= FC_W'(k_init - 4'd1);
        end else if (tick) begin
            fc <= sof ? '0 : fc + 1'b1;
        end
    end
endmodule

// File: rtl/lcdfd_frame_div.sv
module lcdfd_frame_div
    import lcdfd_pkg::*;
#(
    parameter int unsigned PRE_LO_LOG2 = 4,
    parameter int unsigned PRE_HI_LOG2 = 11,
    localparam int unsigned FDW = PRE_HI_LOG2 + CODE_W + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pre_sel,
    input  logic [CODE_W-1:0] div_code,
    input  logic [1:0]        duty,
    output logic              lcd_tick,
    output logic              frame_sof,
    output logic [FDW-1:0]    frame_div
);
    lcd_cfg_t   cfg_in;
    lcd_cfg_t   act;
    logic [3:0] k_act;
    logic [3:0] k_init;
    logic [FDW-1:0] kd;

    assign cfg_in.psel = pre_sel;
    assign cfg_in.code = div_code;
    assign cfg_in.duty = duty_e'(duty);
    assign k_act       = k_of(act.duty);
    assign k_init      = k_of(cfg_in.duty);

    lcdfd_cfg_hold u_hold (
        .clk   (clk),
        .rst   (rst),
        .load  (frame_sof),
        .cfg_in(cfg_in),
        .cfg_q (act)
    );

    lcdfd_prescaler #(
        .PRE_LO_LOG2(PRE_LO_LOG2),
        .PRE_HI_LOG2(PRE_HI_LOG2)
    ) u_pre (
        .clk (clk),
        .rst (rst),
        .psel(act.psel),
        .code(act.code),
        .tick(lcd_tick)
    );

    lcdfd_frame_seq u_seq (
        .clk   (clk),
        .rst   (rst),
        .tick  (lcd_tick),
        .k_act (k_act),
        .k_init(k_init),
        .sof   (frame_sof)
    );

    always_comb begin
        kd = FDW'(k_act) * (FDW'(act.code) + FDW'(1));
        frame_div = act.psel ? (kd << PRE_HI_LOG2) : (kd << PRE_LO_LOG2);
    end
endmodule

// File: rtl/lcdfd_checker.sv
module lcdfd_checker #(
    parameter int unsigned PRE_LO_LOG2 = 4,
    parameter int unsigned PRE_HI_LOG2 = 11,
    parameter int unsigned FDW = 18
) (
    input logic           clk,
    input logic           rst,
    input logic           lcd_tick,
    input logic           frame_sof,
    input logic [FDW-1:0] frame_div
);
    localparam int unsigned MAX_ND  = (1 << PRE_HI_LOG2) * 8;
    localparam int unsigned MIN_DIV = 6 * (1 << PRE_LO_LOG2);
    localparam int unsigned MAX_DIV = 64 * (1 << PRE_HI_LOG2);

    int unsigned gap_cnt;
    int unsigned tick_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_cnt  <= 0;
            tick_cnt <= 0;
        end else begin
            gap_cnt  <= lcd_tick ? 0 : gap_cnt + 1;
            if (frame_sof)     tick_cnt <= 0;
            else if (lcd_tick) tick_cnt <= tick_cnt + 1;
        end
    end

    AST_SOF_WITH_TICK: assert property (@(posedge clk) disable iff (rst)
        frame_sof |-> lcd_tick); // R4
    AST_FRAME_TICKS: assert property (@(posedge clk) disable iff (rst)
        frame_sof |-> (tick_cnt < 8)); // R4
    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        lcd_tick |-> (gap_cnt < MAX_ND)); // R2
    AST_DIV_HELD: assert property (@(posedge clk) disable iff (rst)
        !frame_sof |=> $stable(frame_div)); // R6
    AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
        (frame_div >= FDW'(MIN_DIV)) && (frame_div <= FDW'(MAX_DIV))); // R1
endmodule

bind lcdfd_frame_div lcdfd_checker #(
    .PRE_LO_LOG2(PRE_LO_LOG2),
    .PRE_HI_LOG2(PRE_HI_LOG2),
    .FDW        (FDW)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .lcd_tick (lcd_tick),
    .frame_sof(frame_sof),
    .frame_div(frame_div)
);

// File: tb/lcdfd_frame_div_test.sv
module lcdfd_frame_div_test;
    localparam int LO = 1;
    localparam int HI = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pre_sel = 1'b0;
    logic [2:0] div_code = '0;
    logic [1:0] duty = '0;
    logic lcd_tick, frame_sof;
    logic [HI+6:0] frame_div;

    logic rst_f = 1'b1;
    logic pre_sel_f = 1'b0;
    logic [2:0] div_code_f = '0;
    logic [1:0] duty_f = '0;
    logic tick_f, sof_f;
    logic [17:0] div_f;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    always #4 clk = ~clk;

    lcdfd_frame_div #(.PRE_LO_LOG2(LO), .PRE_HI_LOG2(HI)) uut (
        .clk(clk), .rst(rst), .pre_sel(pre_sel), .div_code(div_code),
        .duty(duty), .lcd_tick(lcd_tick), .frame_sof(frame_sof),
        .frame_div(frame_div));

    lcdfd_frame_div uut_full (
        .clk(clk), .rst(rst_f), .pre_sel(pre_sel_f), .div_code(div_code_f),
        .duty(duty_f), .lcd_tick(tick_f), .frame_sof(sof_f),
        .frame_div(div_f));

    function automatic int k_exp(input logic [1:0] d);
        return (d == 2'b10) ? 6 : 8;
    endfunction

    function automatic int nd_exp(input logic ps, input logic [2:0] c);
        return (ps ? (1 << HI) : (1 << LO)) * (int'(c) + 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    task automatic next_sof(output int n);
        n = 0;
        do begin
            @(negedge clk); #1;
            n++;
        end while (!frame_sof && n < 3000);
    endtask

    task automatic t_run_cfg(input logic ps, input logic [2:0] c, input logic [1:0] d);
        int nd, knd, idx, nsof, s1, s2, t1, t2, tk;
        nd = nd_exp(ps, c);
        knd = k_exp(d) * nd;
        @(negedge clk);
        rst = 1; pre_sel = ps; div_code = c; duty = d;
        repeat (2) @(negedge clk);
        #1;
        chk(!lcd_tick && !frame_sof, "R5 strobes low in reset", int'({lcd_tick, frame_sof}), 0);
        chk(int'(frame_div) == knd, "R1 divisor read-back", int'(frame_div), knd);
        @(negedge clk);
        rst = 0;
        #1;
        idx = 0; nsof = 0; s1 = -1; s2 = -1; t1 = -1; t2 = -1; tk = 0;
        while (nsof < 2 && idx < 2000) begin
            if (lcd_tick) begin
                if (t1 < 0) t1 = idx; else if (t2 < 0) t2 = idx;
                if (nsof == 1) tk++;
            end
            if (frame_sof) begin
                nsof++;
                if (nsof == 1) s1 = idx; else s2 = idx;
            end
            @(negedge clk); #1;
            idx++;
        end
        chk(s1 == nd - 1, "R5 first sof cycle", s1, nd - 1);
        chk(t2 - t1 == nd, "R2 tick period", t2 - t1, nd);
        chk(s2 - s1 == knd, "R3 frame period", s2 - s1, knd);
        chk(tk == k_exp(d), "R4 ticks per frame", tk, k_exp(d));
    endtask

    task automatic t_midframe_change();
        int n;
        @(negedge clk);
        rst = 1; pre_sel = 0; div_code = 3'd1; duty = 2'b00;
        repeat (2) @(negedge clk);
        rst = 0;
        #1;
        if (!frame_sof) next_sof(n);
        repeat (10) @(negedge clk);
        pre_sel = 1; div_code = 3'd2; duty = 2'b10;
        #1;
        chk(int'(frame_div) == 32, "R6 divisor held mid-frame", int'(frame_div), 32);
        next_sof(n);
        chk(n + 10 == 32, "R6 current frame keeps old length", n + 10, 32);
        @(negedge clk); #1;
        chk(int'(frame_div) == 144, "R6 divisor after sof", int'(frame_div), 144);
        next_sof(n);
        chk(n + 1 == 144, "R6 new frame length", n + 1, 144);
    endtask

    task automatic t_full_readback();
        @(negedge clk);
        rst_f = 1; pre_sel_f = 1; div_code_f = 3'd3; duty_f = 2'b11;
        repeat (2) @(negedge clk);
        #1;
        chk(int'(div_f) == 65536, "R7 high ratio example", int'(div_f), 65536);
        pre_sel_f = 0; div_code_f = 3'd4; duty_f = 2'b00;
        repeat (2) @(negedge clk);
        #1;
        chk(int'(div_f) == 640, "R7 low ratio example", int'(div_f), 640);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_run_cfg(1'b0, 3'd0, 2'b00);
        t_run_cfg(1'b1, 3'd3, 2'b10);
        t_run_cfg(1'b0, 3'd7, 2'b01);
        t_run_cfg(1'b1, 3'd7, 2'b11);
        t_run_cfg(1'b1, 3'd4, 2'b10);
        t_midframe_change();
        t_full_readback();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule